// File: doc/BRIEF.md
# Retransmission Timeout and Retry Counter

This block paces the resending of a frame on one network channel. When the host starts a transmission, the block loads a programmable wait. The wait counts in ticks of 100 µs, and a free-running prescaler derives those ticks from the system clock. If no acknowledge arrives before the wait runs out, the block asks for the frame to be sent again, counts that attempt and reloads the wait.

The host programs a retry limit. Once that many resends have run out without an acknowledge, the block raises a single timeout event, which the host's interrupt logic can use, and the block goes idle. An acknowledge stops the sequence quietly. A new start restarts it from the first attempt. Packet content and protocol state stay outside the block.

Top module: `rto_retx_timer`

## Requirements
- R1: After a synchronous reset, `busy`, `retx_req` and `tmo_evt` are all low.
- R2: The prescaler runs freely and emits one tick every CLK_HZ/10000 clock cycles, which is 100 µs. A wait value of N lasts N ticks, so 2000 gives 200 ms. From the start edge to the timeout, a sequence therefore takes between (N·(L+1)−1)·DIV+1 and N·(L+1)·DIV cycles, where L is the retry limit.
- R3: When the wait expires and fewer than L resends have been made, `retx_req` is high for exactly one cycle, `busy` stays high and the wait is reloaded.
- R4: When the wait expires after L resends, `tmo_evt` is high for one cycle and `busy` falls in that same cycle. Each sequence makes L+1 attempts, so it gives L pulses on `retx_req` and one on `tmo_evt`.
- R5: A retry limit of 0 gives a single attempt: no `retx_req` pulse, then `tmo_evt`.
- R6: An acknowledge while busy clears `busy` on the next cycle and raises neither output. If the acknowledge falls in the same cycle as an expiry, the acknowledge wins.
- R7: A wait value of 0 behaves as a wait of 1 tick.
- R8: A start while busy restarts the sequence with the attempt count at zero. Start takes priority over acknowledge and over an expiry in the same cycle, and no event comes from the abandoned sequence.
- R9: The wait value and the retry limit are captured at start. Changes to them during a sequence have no effect on it.
- R10: An acknowledge while idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a transmission sequence |
| ack | input | 1 | Acknowledge received; ends the sequence |
| tmo_val | input | TMO_W | Wait per attempt, in 100 µs ticks |
| retry_lim | input | RCNT_W | Number of resends allowed before timeout |
| retx_req | output | 1 | One-cycle request to resend |
| tmo_evt | output | 1 | One-cycle final timeout event |
| busy | output | 1 | A sequence is in progress |

## Verification
The hard cases are cycles where an acknowledge or a new start coincides with the wait's expiry, since the expiry would otherwise produce a resend or the timeout. The bench provokes this by sweeping the acknowledge, and separately the restart, across every cycle offset of a short one-tick sequence, so that some offsets land exactly on a tick. A behavioural reference model compares the outputs on every clock, and it expects no event from the sequence that lost the race.

// File: rtl/rto_pkg.sv
package rto_pkg;
  localparam int unsigned TICKS_PER_SEC = 10000;

  function automatic int unsigned calc_div(input int unsigned clk_hz);
    int unsigned d;
    d = clk_hz / TICKS_PER_SEC;
    return (d == 0) ? 1 : d;
  endfunction
endpackage

// File: rtl/rto_prescaler.sv
module rto_prescaler #(
  parameter int unsigned DIV = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = tick_q;

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> cnt_q == '0);
endmodule

// File: rtl/rto_wait_timer.sv
module rto_wait_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMO_W-1:0] load_val,
  input  logic             reload,
  input  logic             dec,
  output logic             last
);
  logic [TMO_W-1:0] rem_q, per_q;
  logic [TMO_W-1:0] clamp;

  assign clamp = (load_val == '0) ? TMO_W'(1) : load_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      per_q <= TMO_W'(1);
    end else if (load) begin
      rem_q <= clamp;
      per_q <= clamp;
    end else if (reload) begin
      rem_q <= per_q;
    end else if (dec && rem_q > TMO_W'(1)) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign last = (rem_q == TMO_W'(1));

  assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> rem_q != '0);
  assert_period_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    per_q != '0);
endmodule

// File: rtl/rto_retry_ctr.sv
module rto_retry_ctr #(
  parameter int unsigned RCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [RCNT_W-1:0] limit_in,
  input  logic              inc,
  output logic              exhausted
);
  logic [RCNT_W-1:0] tries_q, lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tries_q <= '0;
      lim_q   <= '0;
    end else if (clear) begin
      tries_q <= '0;
      lim_q   <= limit_in;
    end else if (inc && !exhausted) begin
      tries_q <= tries_q + 1'b1;
    end
  end

  assign exhausted = (tries_q == lim_q);

  assert_tries_bound_R4: assert property (@(posedge clk) disable iff (rst)
    tries_q <= lim_q);
endmodule

// File: rtl/rto_retx_timer.sv
module rto_retx_timer
  import rto_pkg::*;
#(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int unsigned TMO_W  = 16,
  parameter int unsigned RCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ack,
  input  logic [TMO_W-1:0]  tmo_val,
  input  logic [RCNT_W-1:0] retry_lim,
  output logic              retx_req,
  output logic              tmo_evt,
  output logic              busy
);
  localparam int unsigned DIV = calc_div(CLK_HZ);

  logic tick, last, exhausted;
  logic busy_q, retx_q, tmo_q;
  logic step, expire, resend, done;

  rto_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick));

  // a tick only counts while a sequence runs and no start or ack overrides it
  assign step   = busy_q && tick && !start && !ack;
  assign expire = step && last;
  assign resend = expire && !exhausted;
  assign done   = expire && exhausted;

  rto_wait_timer #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst(rst), .load(start), .load_val(tmo_val),
    .reload(resend), .dec(step), .last(last));

  rto_retry_ctr #(.RCNT_W(RCNT_W)) u_retry (
    .clk(clk), .rst(rst), .clear(start), .limit_in(retry_lim),
    .inc(resend), .exhausted(exhausted));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      retx_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      retx_q <= resend;
      tmo_q  <= done;
      if (start)          busy_q <= 1'b1;
      else if (ack||done) busy_q <= 1'b0;
    end
  end

  assign retx_req = retx_q;
  assign tmo_evt  = tmo_q;
  assign busy     = busy_q;

  assert_retx_keeps_busy_R3: assert property (@(posedge clk) disable iff (rst)
    retx_req |-> busy);
  assert_retx_single_R3: assert property (@(posedge clk) disable iff (rst)
    retx_req |=> !retx_req);
  assert_tmo_idle_R4: assert property (@(posedge clk) disable iff (rst)
    tmo_evt |-> !busy && !retx_req);
  assert_ack_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && !start) |=> !busy && !retx_req && !tmo_evt);
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && !tmo_evt && !retx_req);
  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/test_rto_retx_timer.sv
module test_rto_retx_timer;
  localparam int unsigned CLK_HZ = 40000;
  localparam int DIV = 4;
  localparam int TW = 16;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, ack = 1'b0;
  logic [TW-1:0] tmo_val = '0;
  logic [RW-1:0] retry_lim = '0;
  logic retx_req, tmo_evt, busy;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0, finished = 0;

  always #2 clk = ~clk;

  rto_retx_timer #(.CLK_HZ(CLK_HZ), .TMO_W(TW), .RCNT_W(RW)) i_rto_retx_timer (
    .clk(clk), .rst(rst), .start(start), .ack(ack), .tmo_val(tmo_val),
    .retry_lim(retry_lim), .retx_req(retx_req), .tmo_evt(tmo_evt), .busy(busy));

  // behavioural reference model
  int m_cnt = 0, m_rem = 0, m_per = 1, m_lim = 0, m_tries = 0;
  bit m_tick = 0, m_busy = 0, m_retx = 0, m_tmo = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tick = 0; m_busy = 0; m_retx = 0; m_tmo = 0;
    end else begin
      m_retx = 0; m_tmo = 0;
      if (start) begin
        m_busy = 1; m_per = (tmo_val == 0) ? 1 : int'(tmo_val);
        m_rem = m_per; m_lim = int'(retry_lim); m_tries = 0;
      end else if (ack) begin
        m_busy = 0;
      end else if (m_busy && m_tick) begin
        if (m_rem == 1) begin
          if (m_tries == m_lim) begin m_tmo = 1; m_busy = 0; end
          else begin m_retx = 1; m_tries++; m_rem = m_per; end
        end else m_rem--;
      end
      m_tick = (m_cnt == DIV - 1);
      m_cnt = (m_cnt + 1) % DIV;
    end
    cmp_on = 1;
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (cmp_on && !finished) begin
    chk(busy == m_busy, "R1 busy", busy, m_busy);
    chk(retx_req == m_retx, "R3 retx_req", retx_req, m_retx);
    chk(tmo_evt == m_tmo, "R4 tmo_evt", tmo_evt, m_tmo);
  end

  task automatic pulse_start(input int tv, input int rl);
    @(negedge clk);
    tmo_val = TW'(tv); retry_lim = RW'(rl); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // run to completion, count pulses and cycles
  task automatic run_seq(input int tv, input int rl, output int nretx,
                         output int ntmo, output int elapsed);
    nretx = 0; ntmo = 0; elapsed = 0;
    pulse_start(tv, rl);
    while (busy || (elapsed == 0)) begin
      elapsed++;
      if (retx_req) nretx++;
      @(negedge clk);
      if (tmo_evt) ntmo++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    int nr, nt, el, n;
    idle(3);
    chk(!busy && !retx_req && !tmo_evt, "R1 reset state", busy, 0);
    rst = 0;
    idle(5);

    // R3 R4: limit 2 gives two resends then one timeout
    run_seq(3, 2, nr, nt, el);
    chk(nr == 2, "R3 resend count", nr, 2);
    chk(nt == 1, "R4 timeout count", nt, 1);
    n = 3 * 3;
    chk(el >= (n - 1) * DIV && el <= n * DIV + 1, "R2 sequence length", el, n * DIV);

    // R5: single attempt
    run_seq(5, 0, nr, nt, el);
    chk(nr == 0 && nt == 1, "R5 single attempt", nr, 0);

    // R7: zero wait acts as one tick
    run_seq(0, 1, nr, nt, el);
    chk(nr == 1 && nt == 1, "R7 zero wait counts", nr, 1);
    chk(el <= 2 * DIV + 1, "R7 zero wait length", el, 2 * DIV);

    // R6: ack mid sequence
    pulse_start(4, 3);
    idle(6);
    ack = 1; @(negedge clk); ack = 0;
    chk(!busy, "R6 ack stops", busy, 0);
    nr = 0; nt = 0;
    repeat (40) begin if (retx_req) nr++; if (tmo_evt) nt++; @(negedge clk); end
    chk(nr == 0 && nt == 0, "R6 ack silent", nr + nt, 0);

    // R6: ack swept across tick boundaries (coincidence with expiry)
    for (int d = 0; d < 12; d++) begin
      pulse_start(1, 3);
      idle(d);
      ack = 1; @(negedge clk); ack = 0;
      chk(!busy && !tmo_evt, "R6 ack sweep", busy, 0);
      idle(3);
    end

    // R8: restart swept across tick boundaries
    for (int d = 0; d < 12; d++) begin
      pulse_start(1, 1);
      idle(d);
      pulse_start(2, 0);
      chk(busy && !tmo_evt, "R8 restart busy", busy, 1);
      run_seq(2, 0, nr, nt, el);
      chk(nr == 0 && nt == 1, "R8 restart limit", nr, 0);
    end

    // R9: inputs changed mid sequence are ignored
    pulse_start(2, 1);
    tmo_val = 50; retry_lim = 9;
    nr = 0; nt = 0;
    repeat (30) begin if (retx_req) nr++; if (tmo_evt) nt++; @(negedge clk); end
    chk(nr == 1 && nt == 1 && !busy, "R9 captured params", nr, 1);

    // R10: ack while idle
    ack = 1; @(negedge clk); ack = 0;
    chk(!busy && !retx_req && !tmo_evt, "R10 idle ack", busy, 0);
    idle(8);

    // R2: 2000 ticks is 200 ms
    run_seq(2000, 0, nr, nt, el);
    chk(nt == 1, "R2 long timeout fired", nt, 1);
    chk(el >= 1999 * DIV && el <= 2000 * DIV + 1, "R2 200ms length", el, 2000 * DIV);

    idle(4);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end
endmodule